// File: doc/BRIEF.md
# LPC SYNC Phase Tracker

This block follows the synchronisation phase of a Low Pin Count bus cycle on the host side. Once the address and turnaround phases are over, the surrounding cycle engine pulses `startPulse` and gives the kind of cycle in progress. The block then samples the 4-bit bus nibble on every clock. It stays in the phase while the peripheral sends wait codes. When a terminal code arrives, it emits a one-clock outcome strobe. The outcome is one of: completion, completion with more DMA transfers wanted, completion with a system-error event, a protocol violation, a wait timeout, or a no-response timeout.

A terminal code is judged against the cycle kind. Continuation is legal only on DMA cycles. A firmware-hub device may not report an error. On a DMA cycle, a ready or error code also tells the DMA engine that the channel wants no more transfers. On bus-master cycles the host itself answers the phase. The block then drives the nibble: the long-wait code while the host must stall, and the ready code when it can finish.

Top module: `lpc_sync_tracker`

## Requirements
- R1: After reset the block is idle. `busy`, `driveEn` and every outcome strobe are low.
- R2: `startPulse` while idle latches `cycleKind` (00 I/O or memory, 01 DMA, 10 firmware hub, 11 bus master), and `busy` is high from the next clock. The nibble is then judged on each following clock edge. `startPulse` while busy is ignored.
- R3: Code 4'b0000 ends the phase with `doneStb`. On a DMA cycle, `noMoreStb` is also pulsed.
- R4: Codes 4'b0101 and 4'b0110 keep the phase open with no strobe.
- R5: Code 4'b1001 on a DMA cycle pulses `doneStb` and `moreStb`. On any other kind it pulses `violStb` and not `doneStb`.
- R6: Code 4'b1010 pulses `doneStb` and `errStb` (plus `noMoreStb` on DMA). On a firmware-hub cycle it pulses `violStb` only.
- R7: Every other code ends the phase with `violStb` alone.
- R8: If the first 3 samples are all 4'b1111, the phase ends with `noRespStb`. Once any other code has been seen, 4'b1111 counts as a reserved code.
- R9: Short-wait codes in a row are counted. The 9th one in a row ends the phase with `timeoutStb`. A long-wait code resets the run and has no limit of its own.
- R10: `abortReq` while busy ends the phase with `timeoutStb`. It takes priority over the nibble and the stall input.
- R11: On a bus-master cycle the nibble is ignored and `driveEn` is high while busy. With `hostStall` high the block drives 4'b0110 and stays busy. With it low, it drives 4'b0000 and ends with `doneStb`.
- R12: Each strobe lasts one clock. `busy` is low in that clock, and a `startPulse` in that clock is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| startPulse | input | 1 | Begin tracking a SYNC phase |
| cycleKind | input | 2 | Cycle kind, latched at start |
| busNibble | input | 4 | Sampled bus nibble |
| hostStall | input | 1 | Host needs wait states (bus-master cycle) |
| abortReq | input | 1 | Abort the current phase |
| busy | output | 1 | Phase in progress |
| driveEn | output | 1 | Host drives the nibble |
| driveNibble | output | 4 | Code driven by the host |
| doneStb | output | 1 | Phase completed |
| moreStb | output | 1 | DMA wants more transfers |
| errStb | output | 1 | System-error event |
| noMoreStb | output | 1 | DMA channel wants no more transfers |
| violStb | output | 1 | Protocol violation |
| timeoutStb | output | 1 | Short-wait overrun or abort |
| noRespStb | output | 1 | No peripheral answered |

## Verification
The hardest situations to reach are the counted ones. The short-wait overrun needs nine short waits in a row, with no long wait in between. The no-response case needs 4'b1111 on exactly the first samples, and a phase where some other code comes first must reject a later 4'b1111. Random runs bias the nibble toward the wait codes and 4'b1111, so these runs come up often. Directed sequences also land one sample either side of each limit. A start pulse sent partway through a run must not reset the run, and this is shown by the run still timing out on schedule.

// File: rtl/lpc_sync_pkg.sv
package lpc_sync_pkg;
  localparam int NIB_W = 4;

  localparam logic [NIB_W-1:0] CODE_READY = 4'b0000;
  localparam logic [NIB_W-1:0] CODE_SHORT = 4'b0101;
  localparam logic [NIB_W-1:0] CODE_LONG  = 4'b0110;
  localparam logic [NIB_W-1:0] CODE_MORE  = 4'b1001;
  localparam logic [NIB_W-1:0] CODE_ERR   = 4'b1010;
  localparam logic [NIB_W-1:0] CODE_IDLE  = 4'b1111;

  typedef enum logic [1:0] {
    KIND_IOMEM = 2'b00,
    KIND_DMA   = 2'b01,
    KIND_FWH   = 2'b10,
    KIND_BMAST = 2'b11
  } cycleKind_e;

  typedef struct packed {
    logic capture;
    logic evaluate;
  } ctrlStb_t;

  typedef struct packed {
    logic done;
    logic more;
    logic err;
    logic noMore;
    logic viol;
    logic tmo;
    logic noResp;
  } outcome_t;
endpackage

// File: rtl/lpc_sync_ctrl.sv
module lpc_sync_ctrl
  import lpc_sync_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     startPulse,
  input  logic     terminal,
  output logic     busy,
  output ctrlStb_t ctrlStb
);
  typedef enum logic {ST_IDLE, ST_ACTIVE} state_e;
  state_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE:   if (startPulse) stateNext = ST_ACTIVE;
      ST_ACTIVE: if (terminal)   stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign busy             = (state == ST_ACTIVE);
  assign ctrlStb.capture  = (state == ST_IDLE) && startPulse;
  assign ctrlStb.evaluate = (state == ST_ACTIVE);

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startPulse) |=> busy);

  p_term_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && terminal) |=> !busy);
endmodule

// File: rtl/lpc_sync_datapath.sv
module lpc_sync_datapath
  import lpc_sync_pkg::*;
#(
  parameter int NO_RESP_LIMIT    = 3,
  parameter int SHORT_WAIT_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStb_t         ctrlStb,
  input  logic [1:0]       cycleKind,
  input  logic [NIB_W-1:0] busNibble,
  input  logic             hostStall,
  input  logic             abortReq,
  output logic             terminal,
  output logic             driveEn,
  output logic [NIB_W-1:0] driveNibble,
  output outcome_t         stb
);
  localparam int FF_W = $clog2(NO_RESP_LIMIT + 1);
  localparam int SW_W = $clog2(SHORT_WAIT_LIMIT + 1);
  localparam logic [FF_W-1:0] FF_LAST = FF_W'(NO_RESP_LIMIT - 1);
  localparam logic [SW_W-1:0] SW_MAX  = SW_W'(SHORT_WAIT_LIMIT);

  cycleKind_e kindReg;
  logic [FF_W-1:0] ffCnt;
  logic [SW_W-1:0] swCnt;
  logic            inStart;
  outcome_t        outc;
  logic            isDma, isFwh, isBm;

  assign isDma = (kindReg == KIND_DMA);
  assign isFwh = (kindReg == KIND_FWH);
  assign isBm  = (kindReg == KIND_BMAST);

  // Classify the current sample into an outcome
  always_comb begin
    outc     = '0;
    terminal = 1'b0;
    if (ctrlStb.evaluate) begin
      if (abortReq) begin
        outc.tmo = 1'b1;
        terminal = 1'b1;
      end else if (isBm) begin
        if (!hostStall) begin
          outc.done = 1'b1;
          terminal  = 1'b1;
        end
      end else begin
        case (busNibble)
          CODE_READY: begin
            outc.done   = 1'b1;
            outc.noMore = isDma;
            terminal    = 1'b1;
          end
          CODE_SHORT: begin
            if (swCnt == SW_MAX) begin
              outc.tmo = 1'b1;
              terminal = 1'b1;
            end
          end
          CODE_LONG: ;
          CODE_MORE: begin
            terminal = 1'b1;
            if (isDma) begin
              outc.done = 1'b1;
              outc.more = 1'b1;
            end else begin
              outc.viol = 1'b1;
            end
          end
          CODE_ERR: begin
            terminal = 1'b1;
            if (isFwh) begin
              outc.viol = 1'b1;
            end else begin
              outc.done   = 1'b1;
              outc.err    = 1'b1;
              outc.noMore = isDma;
            end
          end
          CODE_IDLE: begin
            if (!inStart) begin
              outc.viol = 1'b1;
              terminal  = 1'b1;
            end else if (ffCnt == FF_LAST) begin
              outc.noResp = 1'b1;
              terminal    = 1'b1;
            end
          end
          default: begin
            outc.viol = 1'b1;
            terminal  = 1'b1;
          end
        endcase
      end
    end
  end

  // Per-phase tracking state
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kindReg <= KIND_IOMEM;
      ffCnt   <= '0;
      swCnt   <= '0;
      inStart <= 1'b0;
    end else if (ctrlStb.capture) begin
      kindReg <= cycleKind_e'(cycleKind);
      ffCnt   <= '0;
      swCnt   <= '0;
      inStart <= 1'b1;
    end else if (ctrlStb.evaluate && !terminal && !isBm) begin
      swCnt <= (busNibble == CODE_SHORT) ? swCnt + 1'b1 : '0;
      if (busNibble == CODE_IDLE && inStart) ffCnt <= ffCnt + 1'b1;
      else                                   inStart <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb <= '0;
    else        stb <= outc;
  end

  assign driveEn     = ctrlStb.evaluate && isBm;
  assign driveNibble = (driveEn && hostStall) ? CODE_LONG : CODE_READY;

  p_single_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.done, stb.viol, stb.tmo, stb.noResp}));

  p_more_dma_r5: assert property (@(posedge clk) disable iff (!rst_n)
    stb.more |-> (stb.done && isDma));

  p_err_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stb.err |-> (stb.done && !isFwh));

  p_sw_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    swCnt <= SW_MAX);

  p_stall_long_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (driveEn && hostStall) |-> (driveNibble == CODE_LONG));

  p_pulse_once_r12: assert property (@(posedge clk) disable iff (!rst_n)
    stb.done |=> !stb.done);
endmodule

// File: rtl/lpc_sync_tracker.sv
module lpc_sync_tracker
  import lpc_sync_pkg::*;
#(
  parameter int NO_RESP_LIMIT    = 3,
  parameter int SHORT_WAIT_LIMIT = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startPulse,
  input  logic [1:0] cycleKind,
  input  logic [3:0] busNibble,
  input  logic       hostStall,
  input  logic       abortReq,
  output logic       busy,
  output logic       driveEn,
  output logic [3:0] driveNibble,
  output logic       doneStb,
  output logic       moreStb,
  output logic       errStb,
  output logic       noMoreStb,
  output logic       violStb,
  output logic       timeoutStb,
  output logic       noRespStb
);
  ctrlStb_t ctrlStb;
  outcome_t stb;
  logic     terminal;

  lpc_sync_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse),
    .terminal(terminal), .busy(busy), .ctrlStb(ctrlStb)
  );

  lpc_sync_datapath #(
    .NO_RESP_LIMIT(NO_RESP_LIMIT), .SHORT_WAIT_LIMIT(SHORT_WAIT_LIMIT)
  ) dp_i (
    .clk(clk), .rst_n(rst_n), .ctrlStb(ctrlStb), .cycleKind(cycleKind),
    .busNibble(busNibble), .hostStall(hostStall), .abortReq(abortReq),
    .terminal(terminal), .driveEn(driveEn), .driveNibble(driveNibble),
    .stb(stb)
  );

  assign doneStb    = stb.done;
  assign moreStb    = stb.more;
  assign errStb     = stb.err;
  assign noMoreStb  = stb.noMore;
  assign violStb    = stb.viol;
  assign timeoutStb = stb.tmo;
  assign noRespStb  = stb.noResp;
endmodule

// File: tb/lpc_sync_tracker_tb_top.sv
module lpc_sync_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startPulse = 1'b0;
  logic [1:0] cycleKind = 2'b00;
  logic [3:0] busNibble = 4'b1111;
  logic hostStall = 1'b0;
  logic abortReq = 1'b0;
  logic busy, driveEn, doneStb, moreStb, errStb, noMoreStb, violStb, timeoutStb, noRespStb;
  logic [3:0] driveNibble;

  int checks = 0;
  int fails = 0;

  // bench reference state
  logic [1:0] mKind = 2'b00;
  bit mActive = 0;
  bit mInStart = 0;
  int mFf = 0;
  int mSw = 0;

  always #2.5 clk = ~clk;

  lpc_sync_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .cycleKind(cycleKind),
    .busNibble(busNibble), .hostStall(hostStall), .abortReq(abortReq),
    .busy(busy), .driveEn(driveEn), .driveNibble(driveNibble),
    .doneStb(doneStb), .moreStb(moreStb), .errStb(errStb), .noMoreStb(noMoreStb),
    .violStb(violStb), .timeoutStb(timeoutStb), .noRespStb(noRespStb)
  );

  // {done,more,err,noMore,viol,tmo,noResp,term}
  function automatic logic [7:0] predict(logic [1:0] k, logic [3:0] n, bit ab, bit st,
                                         bit inS, int ff, int sw);
    logic [7:0] r = 8'b0;
    if (ab) r = 8'b0000_0101;
    else if (k == 2'b11) r = st ? 8'b0 : 8'b1000_0001;
    else case (n)
      4'b0000: r = (k == 2'b01) ? 8'b1001_0001 : 8'b1000_0001;
      4'b0101: r = (sw == 8) ? 8'b0000_0101 : 8'b0;
      4'b0110: r = 8'b0;
      4'b1001: r = (k == 2'b01) ? 8'b1100_0001 : 8'b0000_1001;
      4'b1010: r = (k == 2'b10) ? 8'b0000_1001 :
                   (k == 2'b01) ? 8'b1011_0001 : 8'b1010_0001;
      4'b1111: r = !inS ? 8'b0000_1001 : (ff == 2) ? 8'b0000_0011 : 8'b0;
      default: r = 8'b0000_1001;
    endcase
    return r;
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] observed();
    return {doneStb, moreStb, errStb, noMoreStb, violStb, timeoutStb, noRespStb, !busy};
  endfunction

  task automatic begin_phase(string tag, logic [1:0] k);
    @(negedge clk);
    startPulse = 1'b1; cycleKind = k; abortReq = 1'b0;
    @(posedge clk); #1;
    startPulse = 1'b0;
    if (!mActive) begin
      mActive = 1; mKind = k; mInStart = 1; mFf = 0; mSw = 0;
    end
    check(tag, {7'b0, busy}, 8'h01);
  endtask

  task automatic step(string tag, logic [3:0] n, bit ab, bit st, bit pulseStart);
    logic [7:0] e;
    @(negedge clk);
    busNibble = n; abortReq = ab; hostStall = st; startPulse = pulseStart;
    #1;
    if (mKind == 2'b11)
      check({tag, "_drive"}, {3'b0, driveEn, driveNibble},
            {3'b0, 1'b1, (st ? 4'b0110 : 4'b0000)});
    e = predict(mKind, n, ab, st, mInStart, mFf, mSw);
    @(posedge clk); #1;
    startPulse = 1'b0; abortReq = 1'b0;
    check(tag, observed(), e);
    if (e[0]) mActive = 0;
    else if (!ab && mKind != 2'b11) begin
      mSw = (n == 4'b0101) ? mSw + 1 : 0;
      if (n == 4'b1111 && mInStart) mFf++;
      else mInStart = 0;
    end
  endtask

  task automatic idle_check(string tag);
    @(negedge clk); busNibble = 4'b0000;
    @(posedge clk); #1;
    check(tag, observed(), 8'h01);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset", {observed(), driveEn}, 9'h002 >> 0 ? {8'h01, 1'b0} : 9'h0);
    @(negedge clk); rst_n = 1'b1;

    // R3 ready on IO and DMA
    begin_phase("R2", 2'b00); step("R3 io ready", 4'b0000, 0, 0, 0);
    idle_check("R12 strobe one cycle");
    begin_phase("R2", 2'b01); step("R3 dma ready", 4'b0000, 0, 0, 0);
    // R12 start accepted in strobe cycle, R4 waits
    begin_phase("R12 start in strobe", 2'b01);
    step("R4 short", 4'b0101, 0, 0, 0); step("R4 long", 4'b0110, 0, 0, 0);
    step("R5 dma more", 4'b1001, 0, 0, 0);
    begin_phase("R2", 2'b10); step("R5 fwh more", 4'b1001, 0, 0, 0);
    begin_phase("R2", 2'b10); step("R6 fwh err", 4'b1010, 0, 0, 0);
    begin_phase("R2", 2'b00); step("R6 io err", 4'b1010, 0, 0, 0);
    begin_phase("R2", 2'b01); step("R6 dma err", 4'b1010, 0, 0, 0);
    begin_phase("R2", 2'b00); step("R7 reserved", 4'b0011, 0, 0, 0);
    // R8 no response
    begin_phase("R2", 2'b00);
    for (int i = 0; i < 3; i++) step("R8 no resp", 4'b1111, 0, 0, 0);
    begin_phase("R2", 2'b00);
    step("R8", 4'b1111, 0, 0, 0); step("R8", 4'b1111, 0, 0, 0);
    step("R8 ready after idle", 4'b0000, 0, 0, 0);
    begin_phase("R2", 2'b01);
    step("R8", 4'b0110, 0, 0, 0); step("R8 late idle", 4'b1111, 0, 0, 0);
    // R9 short wait run, with an ignored start mid-run (R2)
    begin_phase("R2", 2'b00);
    for (int i = 0; i < 9; i++) step("R9 short run", 4'b0101, 0, 0, (i == 4));
    begin_phase("R2", 2'b00);
    for (int i = 0; i < 8; i++) step("R9 eight short", 4'b0101, 0, 0, 0);
    step("R9 long resets", 4'b0110, 0, 0, 0);
    for (int i = 0; i < 8; i++) step("R9 again", 4'b0101, 0, 0, 0);
    step("R9 ready", 4'b0000, 0, 0, 0);
    // R10 long wait with abort
    begin_phase("R2", 2'b01);
    for (int i = 0; i < 40; i++) step("R9 long unlimited", 4'b0110, 0, 0, 0);
    step("R10 abort", 4'b0000, 1, 0, 0);
    // R11 bus master
    begin_phase("R2", 2'b11);
    step("R11 stall", 4'b1010, 0, 1, 0); step("R11 stall", 4'b0011, 0, 1, 0);
    step("R11 finish", 4'b1010, 0, 0, 0);
    begin_phase("R2", 2'b11); step("R10 bm abort", 4'b0000, 1, 1, 0);
    idle_check("R12 idle");

    // random phases
    for (int t = 0; t < 400; t++) begin
      logic [1:0] k = 2'($urandom % 4);
      begin_phase("R2 rnd", k);
      for (int s = 0; s < 40 && mActive; s++) begin
        int r = $urandom % 16;
        logic [3:0] n;
        bit ab = (s == 39) || ($urandom % 50 == 0);
        n = (r < 5) ? 4'b0101 : (r < 9) ? 4'b0110 : (r < 11) ? 4'b1111 : 4'($urandom);
        step("R3-R11 random", n, ab, ($urandom % 4 != 0), 0);
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule